// File: doc/BRIEF.md
# USB Host Transfer Descriptor Updater

After each USB host bus transaction, the next overlay state of an endpoint queue's active transfer descriptor has to be worked out. This block does that. The scheduler presents the overlay fields it holds for the endpoint, together with the result of the transaction that just ended. That result gives the token direction, the kind of response and the number of bytes the device delivered. The block then retires the transaction. It moves the transfer forward on a good handshake, counts NAKs and errors, records babble and stalls, and decides whether the descriptor stays active.

One clock after the result strobe, the block registers every updated field. In the same cycle it raises a one-cycle write-back request for the memory side. A completion flag comes with the request whenever Active has just gone from 1 to 0. A cause code gives the single reason for retirement, picked by fixed priority. The page index advances when the byte offset runs past the end of a buffer page. If the number of buffer pages is not a power of two, the index saturates at the last page.

Top module: `usb_qtd_updater`

## Requirements
- R1: While reset is asserted, and before any result strobe, every output reads zero, including the write-back request and the completion flag.
- R2: Response kind 0 is an ACK. An ACK on an OUT token moves the smaller of the endpoint's maximum packet length and the remaining byte count. The byte count drops by that amount, the data toggle inverts, and the 12-bit page offset grows by that amount modulo 4096. On a carry out of the offset, the page index rises by one, holding at 4.
- R3: An ACK on an IN token moves exactly the byte count the device returned, provided that count exceeds neither the remaining byte count nor the maximum packet length. The fields update as in R2.
- R4: Babble is either response kind 6, or an IN ACK whose returned count is larger than the remaining byte count (zero-length transfers included) or larger than the maximum packet length. Babble sets the babble and halted outputs, clears Active and leaves byte count, toggle, offset and page unchanged.
- R5: Response kind 4 is a data-PID mismatch. It leaves the transfer state unchanged. On an IN token to an interrupt endpoint, it decrements the interrupt transaction counter, which does not go below zero.
- R6: Response kinds 1 (NAK) and 2 (NYET) decrement the NAK counter only if the reload value is non-zero, and the counter does not go below zero. When the reload value is zero, no write-back is requested.
- R7: Response kind 5 is a transaction error, and the reserved code 7 is treated the same way. It sets the error status output and leaves the transfer state unchanged. It decrements a non-zero error counter, and when that counter reaches zero it sets halted and clears Active. An error counter that is already zero stays zero and does not halt.
- R8: Response kind 3 (STALL) sets halted and clears Active.
- R9: An ACK that leaves the byte count at zero clears Active with halted low. A zero-length OUT is one such ACK.
- R10: Updated fields, the write-back request and the completion flag all appear one clock after the result strobe. Between strobes the fields hold their values, and both pulses last one cycle. Completion is high exactly when the incoming Active was 1 and the new Active is 0.
- R11: The cause code is 1 for babble, 2 for stall, 3 for error counter exhausted, 4 for byte count drained, and 0 otherwise. When causes coincide, they rank in that order (1 highest), so a zero-length IN that returns data reports 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Transaction result strobe |
| res_tok_in | input | 1 | 1 = IN token, 0 = OUT token |
| res_kind | input | 3 | Response kind (see R2 to R8) |
| res_rx_bytes | input | 11 | Bytes returned by the device on IN |
| ep_max_pkt | input | 11 | Endpoint maximum packet length |
| ep_intr | input | 1 | Endpoint is an interrupt endpoint |
| ov_total | input | 15 | Current remaining byte count |
| ov_toggle | input | 1 | Current data toggle |
| ov_offset | input | 12 | Current page offset |
| ov_page | input | 3 | Current page index |
| ov_cerr | input | 2 | Current error counter |
| ov_nakcnt | input | 4 | Current NAK counter |
| ov_nak_reload | input | 4 | NAK counter reload value |
| ov_itc | input | 2 | Current interrupt transaction counter |
| ov_active | input | 1 | Current Active bit |
| nx_total | output | 15 | Updated byte count |
| nx_toggle | output | 1 | Updated data toggle |
| nx_offset | output | 12 | Updated page offset |
| nx_page | output | 3 | Updated page index |
| nx_cerr | output | 2 | Updated error counter |
| nx_nakcnt | output | 4 | Updated NAK counter |
| nx_itc | output | 2 | Updated interrupt transaction counter |
| nx_active | output | 1 | Updated Active bit |
| nx_halted | output | 1 | Halted status |
| nx_babble | output | 1 | Babble status of the last result |
| nx_xacterr | output | 1 | Transaction-error status of the last result |
| nx_cause | output | 3 | Retirement cause code (R11) |
| wb_req | output | 1 | One-cycle write-back request |
| completed | output | 1 | One-cycle completion flag |

## Verification
The assertions assume three things about the inputs: the overlay fields stay stable and consistent with the strobe in the cycle they are sampled, the page index given is within the five buffer pages, and the reset is held low long enough for the past-value terms to see a quiet strobe. The bench drives every input on the falling edge and keeps the page index between 0 and 4. Beyond the directed cases it issues a run of pseudo-random results over all eight response codes, with Active mostly high. This exercises both the completion flag and its absence when Active was already clear.

// File: rtl/usb_qtd_pkg.sv
package usb_qtd_pkg;

   typedef enum logic [2:0] {
      RESP_ACK    = 3'd0,
      RESP_NAK    = 3'd1,
      RESP_NYET   = 3'd2,
      RESP_STALL  = 3'd3,
      RESP_PIDERR = 3'd4,
      RESP_XERR   = 3'd5,
      RESP_BABBLE = 3'd6
   } resp_e;

   typedef enum logic [2:0] {
      CAUSE_NONE    = 3'd0,
      CAUSE_BABBLE  = 3'd1,
      CAUSE_STALL   = 3'd2,
      CAUSE_ERRCNT  = 3'd3,
      CAUSE_DRAINED = 3'd4
   } cause_e;

endpackage

// File: rtl/qtd_xfer_advance.sv
module qtd_xfer_advance #(
   parameter int BYTES_W    = 15,
   parameter int PAGE_BITS  = 12,
   parameter int PAGE_IDX_W = 3,
   parameter int NUM_PAGES  = 5,
   parameter int MPS_W      = 11
) (
   input  logic                  accept,
   input  logic                  tok_in,
   input  logic [MPS_W-1:0]      rx_bytes,
   input  logic [MPS_W-1:0]      max_pkt,
   input  logic [BYTES_W-1:0]    total,
   input  logic                  toggle,
   input  logic [PAGE_BITS-1:0]  offset,
   input  logic [PAGE_IDX_W-1:0] page,
   output logic [BYTES_W-1:0]    total_n,
   output logic                  toggle_n,
   output logic [PAGE_BITS-1:0]  offset_n,
   output logic [PAGE_IDX_W-1:0] page_n,
   output logic                  drained
);
   localparam int OFF_W = PAGE_BITS + 1;
   localparam logic [PAGE_IDX_W-1:0] LAST_PAGE = PAGE_IDX_W'(NUM_PAGES - 1);

   logic [MPS_W-1:0]      moved;
   logic [BYTES_W-1:0]    remain;
   logic [OFF_W-1:0]      off_sum;
   logic [PAGE_IDX_W-1:0] pg_step;

   always_comb begin
      if (tok_in)
         moved = rx_bytes;
      else if (total < BYTES_W'(max_pkt))
         moved = total[MPS_W-1:0];
      else
         moved = max_pkt;
   end

   assign remain  = total - BYTES_W'(moved);
   assign off_sum = {1'b0, offset} + OFF_W'(moved);

   generate
      if (NUM_PAGES == (1 << PAGE_IDX_W)) begin : g_page_wrap
         assign pg_step = page + PAGE_IDX_W'(1);
      end else begin : g_page_sat
         assign pg_step = (page >= LAST_PAGE) ? LAST_PAGE : page + PAGE_IDX_W'(1);
      end
   endgenerate

   assign total_n  = accept ? remain : total;
   assign toggle_n = accept ? ~toggle : toggle;
   assign offset_n = accept ? off_sum[PAGE_BITS-1:0] : offset;
   assign page_n   = (accept && off_sum[PAGE_BITS]) ? pg_step : page;
   assign drained  = accept && (remain == '0);

endmodule

// File: rtl/qtd_retry_counters.sv
module qtd_retry_counters #(
   parameter int CERR_W = 2,
   parameter int NAK_W  = 4,
   parameter int ITC_W  = 2
) (
   input  logic              is_nak,
   input  logic              is_xerr,
   input  logic              is_pid,
   input  logic              tok_in,
   input  logic              intr,
   input  logic [CERR_W-1:0] cerr,
   input  logic [NAK_W-1:0]  nakcnt,
   input  logic [NAK_W-1:0]  reload,
   input  logic [ITC_W-1:0]  itc,
   output logic [CERR_W-1:0] cerr_n,
   output logic [NAK_W-1:0]  nakcnt_n,
   output logic [ITC_W-1:0]  itc_n,
   output logic              exhausted,
   output logic              skip_wb
);
   logic cerr_dec, nak_dec, itc_dec;

   assign cerr_dec = is_xerr && (cerr != '0);
   assign nak_dec  = is_nak && (reload != '0) && (nakcnt != '0);
   assign itc_dec  = is_pid && tok_in && intr && (itc != '0);

   assign cerr_n    = cerr_dec ? cerr - CERR_W'(1) : cerr;
   assign nakcnt_n  = nak_dec ? nakcnt - NAK_W'(1) : nakcnt;
   assign itc_n     = itc_dec ? itc - ITC_W'(1) : itc;
   assign exhausted = is_xerr && (cerr == CERR_W'(1));
   assign skip_wb   = is_nak && (reload == '0);

endmodule

// File: rtl/qtd_retire_arbiter.sv
module qtd_retire_arbiter
   import usb_qtd_pkg::*;
(
   input  logic   active_in,
   input  logic   babble,
   input  logic   stall,
   input  logic   exhausted,
   input  logic   drained,
   output logic   active_n,
   output logic   halted_n,
   output cause_e cause
);
   always_comb begin
      if (babble)
         cause = CAUSE_BABBLE;
      else if (stall)
         cause = CAUSE_STALL;
      else if (exhausted)
         cause = CAUSE_ERRCNT;
      else if (drained)
         cause = CAUSE_DRAINED;
      else
         cause = CAUSE_NONE;
   end

   assign halted_n = (cause == CAUSE_BABBLE) || (cause == CAUSE_STALL) ||
                     (cause == CAUSE_ERRCNT);
   assign active_n = active_in && (cause == CAUSE_NONE);

endmodule

// File: rtl/usb_qtd_updater.sv
module usb_qtd_updater
   import usb_qtd_pkg::*;
#(
   parameter int BYTES_W    = 15,
   parameter int PAGE_BITS  = 12,
   parameter int PAGE_IDX_W = 3,
   parameter int NUM_PAGES  = 5,
   parameter int MPS_W      = 11,
   parameter int CERR_W     = 2,
   parameter int NAK_W      = 4,
   parameter int ITC_W      = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  res_valid,
   input  logic                  res_tok_in,
   input  logic [2:0]            res_kind,
   input  logic [MPS_W-1:0]      res_rx_bytes,
   input  logic [MPS_W-1:0]      ep_max_pkt,
   input  logic                  ep_intr,
   input  logic [BYTES_W-1:0]    ov_total,
   input  logic                  ov_toggle,
   input  logic [PAGE_BITS-1:0]  ov_offset,
   input  logic [PAGE_IDX_W-1:0] ov_page,
   input  logic [CERR_W-1:0]     ov_cerr,
   input  logic [NAK_W-1:0]      ov_nakcnt,
   input  logic [NAK_W-1:0]      ov_nak_reload,
   input  logic [ITC_W-1:0]      ov_itc,
   input  logic                  ov_active,
   output logic [BYTES_W-1:0]    nx_total,
   output logic                  nx_toggle,
   output logic [PAGE_BITS-1:0]  nx_offset,
   output logic [PAGE_IDX_W-1:0] nx_page,
   output logic [CERR_W-1:0]     nx_cerr,
   output logic [NAK_W-1:0]      nx_nakcnt,
   output logic [ITC_W-1:0]      nx_itc,
   output logic                  nx_active,
   output logic                  nx_halted,
   output logic                  nx_babble,
   output logic                  nx_xacterr,
   output logic [2:0]            nx_cause,
   output logic                  wb_req,
   output logic                  completed
);
   initial begin : param_checks
      assert (MPS_W < BYTES_W) else $error("packet length wider than byte count");
      assert (MPS_W <= PAGE_BITS) else $error("packet may span more than one page");
      assert (NUM_PAGES >= 1 && NUM_PAGES <= (1 << PAGE_IDX_W))
         else $error("page count does not fit the page index");
      assert (CERR_W >= 1 && NAK_W >= 1 && ITC_W >= 1) else $error("counter width zero");
   end

   resp_e kind;
   logic  is_ack, is_nak, is_stall, is_pid, is_xerr, over_run, babble, accept;

   assign kind     = resp_e'(res_kind);
   assign is_ack   = (kind == RESP_ACK);
   assign is_nak   = (kind == RESP_NAK) || (kind == RESP_NYET);
   assign is_stall = (kind == RESP_STALL);
   assign is_pid   = (kind == RESP_PIDERR);
   assign is_xerr  = (kind == RESP_XERR) || (res_kind == 3'd7);
   assign over_run = res_tok_in && is_ack &&
                     ((BYTES_W'(res_rx_bytes) > ov_total) || (res_rx_bytes > ep_max_pkt));
   assign babble   = over_run || (kind == RESP_BABBLE);
   assign accept   = is_ack && !babble;

   logic [BYTES_W-1:0]    total_n;
   logic                  toggle_n, drained;
   logic [PAGE_BITS-1:0]  offset_n;
   logic [PAGE_IDX_W-1:0] page_n;

   qtd_xfer_advance #(
      .BYTES_W(BYTES_W), .PAGE_BITS(PAGE_BITS), .PAGE_IDX_W(PAGE_IDX_W),
      .NUM_PAGES(NUM_PAGES), .MPS_W(MPS_W)
   ) u_xfer (
      .accept(accept), .tok_in(res_tok_in), .rx_bytes(res_rx_bytes),
      .max_pkt(ep_max_pkt), .total(ov_total), .toggle(ov_toggle),
      .offset(ov_offset), .page(ov_page), .total_n(total_n),
      .toggle_n(toggle_n), .offset_n(offset_n), .page_n(page_n),
      .drained(drained)
   );

   logic [CERR_W-1:0] cerr_n;
   logic [NAK_W-1:0]  nakcnt_n;
   logic [ITC_W-1:0]  itc_n;
   logic              exhausted, skip_wb;

   qtd_retry_counters #(
      .CERR_W(CERR_W), .NAK_W(NAK_W), .ITC_W(ITC_W)
   ) u_cnt (
      .is_nak(is_nak), .is_xerr(is_xerr), .is_pid(is_pid),
      .tok_in(res_tok_in), .intr(ep_intr), .cerr(ov_cerr),
      .nakcnt(ov_nakcnt), .reload(ov_nak_reload), .itc(ov_itc),
      .cerr_n(cerr_n), .nakcnt_n(nakcnt_n), .itc_n(itc_n),
      .exhausted(exhausted), .skip_wb(skip_wb)
   );

   logic   active_n, halted_n;
   cause_e cause;

   qtd_retire_arbiter u_arb (
      .active_in(ov_active), .babble(babble), .stall(is_stall),
      .exhausted(exhausted), .drained(drained), .active_n(active_n),
      .halted_n(halted_n), .cause(cause)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nx_total   <= '0;
         nx_toggle  <= 1'b0;
         nx_offset  <= '0;
         nx_page    <= '0;
         nx_cerr    <= '0;
         nx_nakcnt  <= '0;
         nx_itc     <= '0;
         nx_active  <= 1'b0;
         nx_halted  <= 1'b0;
         nx_babble  <= 1'b0;
         nx_xacterr <= 1'b0;
         nx_cause   <= '0;
         wb_req     <= 1'b0;
         completed  <= 1'b0;
      end else begin
         wb_req    <= res_valid && !skip_wb;
         completed <= res_valid && ov_active && !active_n;
         if (res_valid) begin
            nx_total   <= total_n;
            nx_toggle  <= toggle_n;
            nx_offset  <= offset_n;
            nx_page    <= page_n;
            nx_cerr    <= cerr_n;
            nx_nakcnt  <= nakcnt_n;
            nx_itc     <= itc_n;
            nx_active  <= active_n;
            nx_halted  <= halted_n;
            nx_babble  <= babble;
            nx_xacterr <= is_xerr;
            nx_cause   <= cause;
         end
      end
   end

   assert_wb_after_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req |-> $past(res_valid));

   assert_completion_drops_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
      completed |-> (wb_req && !nx_active));

   assert_stall_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(res_valid) && $past(res_kind) == 3'd3) |-> (nx_halted && !nx_active));

   assert_babble_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      nx_babble |-> (nx_halted && nx_cause == 3'd1));

   assert_nak_no_writeback_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(res_valid) && $past(is_nak) && $past(ov_nak_reload) == '0) |-> !wb_req);

   assert_total_not_growing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(res_valid) |-> (nx_total <= $past(ov_total)));

   assert_cerr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(res_valid) && $past(is_xerr) && $past(ov_cerr) != '0)
         |-> (nx_cerr == CERR_W'($past(ov_cerr) - 1)));

endmodule

// File: tb/usb_qtd_updater_tb.sv
module usb_qtd_updater_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        res_valid = 1'b0, res_tok_in = 1'b0, ep_intr = 1'b0;
   logic [2:0]  res_kind = '0;
   logic [10:0] res_rx_bytes = '0, ep_max_pkt = '0;
   logic [14:0] ov_total = '0;
   logic        ov_toggle = 1'b0, ov_active = 1'b0;
   logic [11:0] ov_offset = '0;
   logic [2:0]  ov_page = '0;
   logic [1:0]  ov_cerr = '0, ov_itc = '0;
   logic [3:0]  ov_nakcnt = '0, ov_nak_reload = '0;

   logic [14:0] nx_total;
   logic        nx_toggle, nx_active, nx_halted, nx_babble, nx_xacterr, wb_req, completed;
   logic [11:0] nx_offset;
   logic [2:0]  nx_page, nx_cause;
   logic [1:0]  nx_cerr, nx_itc;
   logic [3:0]  nx_nakcnt;

   usb_qtd_updater dut_i (
      .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_tok_in(res_tok_in),
      .res_kind(res_kind), .res_rx_bytes(res_rx_bytes), .ep_max_pkt(ep_max_pkt),
      .ep_intr(ep_intr), .ov_total(ov_total), .ov_toggle(ov_toggle),
      .ov_offset(ov_offset), .ov_page(ov_page), .ov_cerr(ov_cerr),
      .ov_nakcnt(ov_nakcnt), .ov_nak_reload(ov_nak_reload), .ov_itc(ov_itc),
      .ov_active(ov_active), .nx_total(nx_total), .nx_toggle(nx_toggle),
      .nx_offset(nx_offset), .nx_page(nx_page), .nx_cerr(nx_cerr),
      .nx_nakcnt(nx_nakcnt), .nx_itc(nx_itc), .nx_active(nx_active),
      .nx_halted(nx_halted), .nx_babble(nx_babble), .nx_xacterr(nx_xacterr),
      .nx_cause(nx_cause), .wb_req(wb_req), .completed(completed)
   );

   always #5 clk = ~clk;

   int    checks = 0;
   int    fails  = 0;
   string tag    = "R1";
   bit    finished = 1'b0;

   // behavioural reference state
   int e_total, e_tog, e_off, e_pg, e_cerr, e_nak, e_itc, e_act, e_halt;
   int e_bab, e_xe, e_cause, e_wb, e_cmp;

   always @(posedge clk) begin
      if (!rst_n) begin
         e_total = 0; e_tog = 0; e_off = 0; e_pg = 0; e_cerr = 0; e_nak = 0;
         e_itc = 0; e_act = 0; e_halt = 0; e_bab = 0; e_xe = 0; e_cause = 0;
         e_wb = 0; e_cmp = 0;
      end else if (!res_valid) begin
         e_wb = 0; e_cmp = 0;
      end else begin
         int k, t, tog, off, pg, ce, nk, it, act, halt, bab, xe, cause, wb, mv, rx, mp;
         k = res_kind; t = ov_total; tog = ov_toggle; off = ov_offset; pg = ov_page;
         ce = ov_cerr; nk = ov_nakcnt; it = ov_itc; act = ov_active;
         rx = res_rx_bytes; mp = ep_max_pkt;
         halt = 0; bab = 0; xe = 0; cause = 0; wb = 1;
         if (k == 6 || (k == 0 && res_tok_in && (rx > t || rx > mp))) begin
            bab = 1; halt = 1; act = 0; cause = 1;
         end else if (k == 0) begin
            mv = res_tok_in ? rx : (mp < t ? mp : t);
            t = t - mv; tog = 1 - tog; off = off + mv;
            if (off >= 4096) begin
               off = off - 4096;
               pg = (pg + 1 > 4) ? 4 : pg + 1;
            end
            if (t == 0) begin act = 0; cause = 4; end
         end else if (k == 1 || k == 2) begin
            if (ov_nak_reload != 0) begin
               if (nk > 0) nk = nk - 1;
            end else wb = 0;
         end else if (k == 3) begin
            halt = 1; act = 0; cause = 2;
         end else if (k == 4) begin
            if (res_tok_in && ep_intr && it > 0) it = it - 1;
         end else begin
            xe = 1;
            if (ce > 0) begin
               ce = ce - 1;
               if (ce == 0) begin halt = 1; act = 0; cause = 3; end
            end
         end
         e_cmp = (ov_active && act == 0) ? 1 : 0;
         e_total = t; e_tog = tog; e_off = off; e_pg = pg; e_cerr = ce; e_nak = nk;
         e_itc = it; e_act = act; e_halt = halt; e_bab = bab; e_xe = xe;
         e_cause = cause; e_wb = wb;
      end
   end

   task automatic chk(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      #3;
      if (!finished) begin
         chk("total", nx_total, e_total);
         chk("toggle", nx_toggle, e_tog);
         chk("offset", nx_offset, e_off);
         chk("page", nx_page, e_pg);
         chk("cerr", nx_cerr, e_cerr);
         chk("nakcnt", nx_nakcnt, e_nak);
         chk("itc", nx_itc, e_itc);
         chk("active", nx_active, e_act);
         chk("halted", nx_halted, e_halt);
         chk("babble", nx_babble, e_bab);
         chk("xacterr", nx_xacterr, e_xe);
         chk("cause", nx_cause, e_cause);
         chk("wb_req", wb_req, e_wb);
         chk("completed", completed, e_cmp);
      end
   end

   task automatic give(input string t_tag, input bit tin, input int kind, input int rx,
                       input int mps, input bit intr, input int total, input int off,
                       input int pg, input int ce, input int nk, input int rl,
                       input int it, input bit act);
      @(negedge clk);
      tag = t_tag;
      res_valid = 1'b1; res_tok_in = tin; res_kind = 3'(kind);
      res_rx_bytes = 11'(rx); ep_max_pkt = 11'(mps); ep_intr = intr;
      ov_total = 15'(total); ov_toggle = ~ov_toggle; ov_offset = 12'(off);
      ov_page = 3'(pg); ov_cerr = 2'(ce); ov_nakcnt = 4'(nk);
      ov_nak_reload = 4'(rl); ov_itc = 2'(it); ov_active = act;
      @(negedge clk);
      res_valid = 1'b0;
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin : stim
      tag = "R1";
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R2 OUT moves max packet, then the short remainder drains (R9)
      give("R2", 0, 0, 0, 512, 0, 1000, 100, 0, 3, 0, 0, 0, 1);
      give("R9", 0, 0, 0, 512, 0, 100, 612, 0, 3, 0, 0, 0, 1);
      // R2 page crossing and saturation at last page
      give("R2", 0, 0, 0, 512, 0, 3000, 4000, 1, 3, 0, 0, 0, 1);
      give("R2", 0, 0, 0, 512, 0, 3000, 4000, 4, 3, 0, 0, 0, 1);
      // R3 IN with short data
      give("R3", 1, 0, 64, 512, 0, 200, 10, 2, 2, 0, 0, 0, 1);
      give("R3", 1, 0, 512, 512, 0, 512, 3584, 0, 2, 0, 0, 0, 1);
      // R4 babble cases; R11 zero-length IN with data reports babble
      give("R11", 1, 0, 8, 512, 0, 0, 0, 0, 3, 0, 0, 0, 1);
      give("R4", 1, 0, 600, 512, 0, 2000, 0, 0, 3, 0, 0, 0, 1);
      give("R4", 1, 6, 0, 64, 0, 50, 7, 1, 3, 0, 0, 0, 1);
      // R5 PID mismatch
      give("R5", 1, 4, 40, 64, 1, 300, 5, 0, 3, 0, 0, 3, 1);
      give("R5", 1, 4, 40, 64, 0, 300, 5, 0, 3, 0, 0, 3, 1);
      give("R5", 1, 4, 40, 64, 1, 300, 5, 0, 3, 0, 0, 0, 1);
      // R6 NAK / NYET
      give("R6", 1, 1, 0, 64, 0, 300, 5, 0, 3, 3, 5, 0, 1);
      give("R6", 1, 2, 0, 64, 0, 300, 5, 0, 3, 3, 0, 0, 1);
      give("R6", 1, 2, 0, 64, 0, 300, 5, 0, 3, 0, 2, 0, 1);
      // R7 transaction errors
      give("R7", 0, 5, 0, 64, 0, 300, 5, 0, 3, 0, 0, 0, 1);
      give("R7", 0, 5, 0, 64, 0, 300, 5, 0, 1, 0, 0, 0, 1);
      give("R7", 1, 5, 0, 64, 0, 300, 5, 0, 0, 0, 0, 0, 1);
      give("R7", 1, 7, 0, 64, 0, 300, 5, 0, 2, 0, 0, 0, 1);
      // R8 stall
      give("R8", 0, 3, 0, 64, 0, 300, 5, 0, 3, 0, 0, 0, 1);
      // R9 zero-length OUT and zero-length IN without data
      give("R9", 0, 0, 0, 64, 0, 0, 9, 0, 3, 0, 0, 0, 1);
      give("R9", 1, 0, 0, 64, 0, 0, 9, 0, 3, 0, 0, 0, 1);
      // R10 inactive descriptor gives no completion, then idle hold
      give("R10", 0, 3, 0, 64, 0, 300, 5, 0, 3, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      // R10 back-to-back strobes
      @(negedge clk);
      tag = "R10";
      res_valid = 1'b1; res_kind = 3'd0; res_tok_in = 1'b0; ep_max_pkt = 11'd64;
      ov_total = 15'd100; ov_offset = 12'd0; ov_page = 3'd0; ov_active = 1'b1;
      @(negedge clk);
      ov_total = 15'd36;
      @(negedge clk);
      res_valid = 1'b0;
      // mixed pseudo-random results
      for (int i = 0; i < 400; i++) begin
         int kk;
         kk = $urandom_range(0, 7);
         give(kk == 0 ? "R3" : kk == 1 ? "R6" : kk == 3 ? "R8" : kk == 4 ? "R5" :
              kk == 6 ? "R4" : kk == 2 ? "R6" : "R7",
              1'($urandom_range(0, 1)), kk, $urandom_range(0, 1100),
              $urandom_range(1, 1024), 1'($urandom_range(0, 1)),
              $urandom_range(0, 2000), $urandom_range(0, 4095), $urandom_range(0, 4),
              $urandom_range(0, 3), $urandom_range(0, 15), $urandom_range(0, 3),
              $urandom_range(0, 3), ($urandom_range(0, 7) != 0));
      end
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule